// File: doc/BRIEF.md
# B3ZS/AMI Dual-Rail Line Decoder

This block takes a bipolar line signal that arrives as two sampled rails: one rail is high for a positive pulse and the other is high for a negative pulse. On each recovered clock it turns the line symbol back into one unipolar data bit. Any pulse, of either polarity, is a one. A bit period with no pulse is a zero. A mode input chooses between plain alternate-mark-inversion decoding and B3ZS decoding. In B3ZS mode the substitution codes that stand in for three zeros are found and returned to three zero bits.

The decoder keeps the polarity of the last single-rail pulse. Any pulse with that same polarity is a polarity violation. In B3ZS mode a violation pulse that closes a two-position "no pulse, no pulse" context is a 00V code. A violation pulse that closes an "alternating pulse, no pulse" context is a B0V code. Both codes decode as zeros. The B position of a B0V code is still held in a short delay line when its V arrives, so it can be cleared before it leaves. Every other violation is reported as a line code error. So is a symbol with both rails high. A one-cycle pulse flags each error, and a saturating counter counts them. A synchronous input clears the counter.

Top module: `b3zs_rail_decoder`

## Requirements
- R1: While rst_n is low, out_bit, out_valid and viol_pulse are 0 and viol_count is 0.
- R2: The bit for the symbol sampled at rising edge n (edges counted from 0 after reset release) is on out_bit from edge n+2 until edge n+3. out_valid is 0 until edge 2, then stays 1.
- R3: With mode_b3zs = 0 (AMI), a symbol with exactly one rail high decodes as 1 and a symbol with no rail high decodes as 0. A single-rail pulse with the same polarity as the previous single-rail pulse decodes as 1 and is a violation. This holds however many empty symbols lie between the two pulses, and substitution codes are not undone.
- R4: With mode_b3zs = 1 (B3ZS), a same-polarity pulse whose two preceding symbols were both empty (00V) decodes as 0 and is not a violation. The two empty positions also decode as 0.
- R5: With mode_b3zs = 1, a same-polarity pulse preceded by an empty symbol that was itself preceded by an alternating single-rail pulse (B0V) decodes as 0. The B position is also output as 0, and no violation is raised.
- R6: With mode_b3zs = 1, a same-polarity pulse without either context decodes as 1 and is a violation. This includes a pulse right after another pulse, and a pulse whose context is an empty symbol after an earlier violation pulse.
- R7: A symbol with both rails high decodes as 1 and is a violation in either mode. It does not change the stored last-pulse polarity.
- R8: A violation in the symbol sampled at edge n makes viol_pulse 1 for exactly the cycle after edge n. The same edge adds 1 to viol_count.
- R9: viol_count (CNT_W = 16 bits) stops at 65535 and does not wrap.
- R10: cnt_clr high at an edge sets viol_count to 0 at that edge, or to 1 if the symbol sampled at the same edge is a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered line clock, one symbol per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_b3zs | input | 1 | 1 = B3ZS decoding, 0 = AMI decoding |
| pos_in | input | 1 | Positive-pulse rail, 1 = positive pulse in this symbol |
| neg_in | input | 1 | Negative-pulse rail, 1 = negative pulse in this symbol |
| cnt_clr | input | 1 | Synchronous clear of the violation counter |
| out_bit | output | 1 | Decoded unipolar data bit |
| out_valid | output | 1 | out_bit carries a decoded symbol |
| viol_pulse | output | 1 | One-cycle line code violation flag |
| viol_count | output | CNT_W | Saturating violation count |

## Verification
Two events can land on the same edge. The first is a B0V violation pulse arriving while the B bit it must erase is leaving the delay line. Long pseudo-random bit streams are run through a B3ZS encoder in the bench to provoke it, and every decoded bit is compared against the original data with no violation expected. The second is a counter clear arriving in the same cycle as a violation. It is provoked by holding cnt_clr high during a both-rails symbol, right after the counter has been driven to saturation, and the count is expected to restart at 1, not 0.

// File: rtl/b3zs_rail_decoder.sv
module b3zs_rail_decoder #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_b3zs,
  input  logic             pos_in,
  input  logic             neg_in,
  input  logic             cnt_clr,
  output logic             out_bit,
  output logic             out_valid,
  output logic             viol_pulse,
  output logic [CNT_W-1:0] viol_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0] K_ZERO = 2'd0;
  localparam logic [1:0] K_B    = 2'd1;
  localparam logic [1:0] K_X    = 2'd2;

  logic       have_pol, last_pos;
  logic       d1, d2, v1, v2;
  logic [1:0] k1, k2;

  wire single   = pos_in ^ neg_in;
  wire any      = pos_in | neg_in;
  wire same_pol = single & have_pol & (pos_in == last_pos);
  wire ctx_00v  = (k1 == K_ZERO) && (k2 == K_ZERO);
  wire ctx_b0v  = (k1 == K_ZERO) && (k2 == K_B);
  wire subst    = mode_b3zs & same_pol & (ctx_00v | ctx_b0v);
  wire viol_now = (pos_in & neg_in) | (same_pol & ~subst);
  wire cur_bit  = any & ~subst;

  logic [1:0] kind_now;
  always_comb begin
    if (!any)                  kind_now = K_ZERO;
    else if (single && !same_pol) kind_now = K_B;
    else                       kind_now = K_X;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_pol   <= 1'b0;
      last_pos   <= 1'b0;
      d1         <= 1'b0;
      d2         <= 1'b0;
      k1         <= K_ZERO;
      k2         <= K_ZERO;
      v1         <= 1'b0;
      v2         <= 1'b0;
      out_bit    <= 1'b0;
      out_valid  <= 1'b0;
      viol_pulse <= 1'b0;
      viol_count <= '0;
    end else begin
      if (single) begin
        have_pol <= 1'b1;
        last_pos <= pos_in;
      end
      d1         <= cur_bit;
      d2         <= d1;
      out_bit    <= (subst && ctx_b0v) ? 1'b0 : d2;
      k1         <= kind_now;
      k2         <= k1;
      v1         <= 1'b1;
      v2         <= v1;
      out_valid  <= v2;
      viol_pulse <= viol_now;
      if (cnt_clr)
        viol_count <= {{(CNT_W-1){1'b0}}, viol_now};
      else if (viol_now && viol_count != CNT_MAX)
        viol_count <= viol_count + 1'b1;
    end
  end

endmodule

// File: rtl/b3zs_rail_decoder_chk.sv
module b3zs_rail_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_b3zs,
  input logic             pos_in,
  input logic             neg_in,
  input logic             cnt_clr,
  input logic             out_bit,
  input logic             out_valid,
  input logic             viol_pulse,
  input logic [CNT_W-1:0] viol_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_valid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  assert_ami_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(mode_b3zs, 1) && !$past(mode_b3zs, 3))
      |-> (out_bit == $past(pos_in | neg_in, 3)));

  assert_both_rails_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_in && neg_in) |=> viol_pulse);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && viol_count != CNT_MAX)
      |=> (viol_count == $past(viol_count) + CNT_W'(viol_pulse)));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && viol_count == CNT_MAX) |=> (viol_count == CNT_MAX));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (viol_count == CNT_W'(viol_pulse)));

endmodule

bind b3zs_rail_decoder b3zs_rail_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_b3zs(mode_b3zs), .pos_in(pos_in),
  .neg_in(neg_in), .cnt_clr(cnt_clr), .out_bit(out_bit),
  .out_valid(out_valid), .viol_pulse(viol_pulse), .viol_count(viol_count)
);

// File: tb/tb_b3zs_rail_decoder.sv
module tb_b3zs_rail_decoder;

  logic        clk = 1'b0;
  logic        rst_n, mode_b3zs, pos_in, neg_in, cnt_clr;
  logic        out_bit, out_valid, viol_pulse;
  logic [15:0] viol_count;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  b3zs_rail_decoder dut (
    .clk(clk), .rst_n(rst_n), .mode_b3zs(mode_b3zs), .pos_in(pos_in),
    .neg_in(neg_in), .cnt_clr(cnt_clr), .out_bit(out_bit),
    .out_valid(out_valid), .viol_pulse(viol_pulse), .viol_count(viol_count)
  );

  logic  eb [0:4095];
  string et [0:4095];
  int    idx;
  int    exp_cnt;
  logic  lastp;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (symbol %0d)", req, act, exp, idx);
    end
  endtask

  task automatic begin_phase(input logic m);
    @(negedge clk);
    rst_n = 1'b0; mode_b3zs = m; pos_in = 1'b0; neg_in = 1'b0; cnt_clr = 1'b0;
    @(negedge clk);
    check("R1", {29'd0, out_bit, out_valid, viol_pulse}, 32'd0);
    check("R1", {16'd0, viol_count}, 32'd0);
    rst_n = 1'b1;
    idx = 0; exp_cnt = 0; lastp = 1'b0;
  endtask

  task automatic drive(input logic p, input logic n, input logic b, input logic v, input string tag);
    pos_in = p; neg_in = n;
    eb[idx % 4096] = b; et[idx % 4096] = tag;
    if (v) exp_cnt++;
    @(negedge clk);
    check(v ? tag : "R8", {31'd0, viol_pulse}, {31'd0, v});
    check("R8", {16'd0, viol_count}, exp_cnt);
    if (idx >= 2) begin
      check("R2", {31'd0, out_valid}, 32'd1);
      check(et[(idx-2) % 4096], {31'd0, out_bit}, {31'd0, eb[(idx-2) % 4096]});
    end else
      check("R2", {31'd0, out_valid}, 32'd0);
    idx++;
  endtask

  task automatic pulse(input logic pol, input logic b, input logic v, input string tag);
    drive(pol, ~pol, b, v, tag);
  endtask

  task automatic empty(input string tag);
    drive(1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  logic data [0:599];

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int nb;
    int i;
    rst_n = 1'b0; mode_b3zs = 1'b0; pos_in = 1'b0; neg_in = 1'b0; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);

    begin_phase(1'b0);
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(1, 0) == 1) begin
        lastp = ~lastp; pulse(lastp, 1'b1, 1'b0, "R3");
      end else empty("R3");
    end
    pulse(lastp, 1'b1, 1'b1, "R3");
    empty("R3"); empty("R3");
    pulse(lastp, 1'b1, 1'b1, "R3");
    lastp = ~lastp; pulse(lastp, 1'b1, 1'b0, "R3");
    drive(1'b1, 1'b1, 1'b1, 1'b1, "R7");
    lastp = ~lastp; pulse(lastp, 1'b1, 1'b0, "R7");
    empty("R3"); empty("R3");

    begin_phase(1'b1);
    for (int k = 0; k < 600; k++) data[k] = (k == 0) ? 1'b1 : 1'($urandom_range(1, 0));
    nb = 0; i = 0;
    while (i < 600) begin
      if (i + 2 < 600 && !data[i] && !data[i+1] && !data[i+2]) begin
        if (nb % 2 == 1) begin
          empty("R4"); empty("R4");
          pulse(lastp, 1'b0, 1'b0, "R4");
        end else begin
          lastp = ~lastp;
          pulse(lastp, 1'b0, 1'b0, "R5");
          empty("R5");
          pulse(lastp, 1'b0, 1'b0, "R5");
        end
        nb = 0; i += 3;
      end else begin
        if (data[i]) begin
          lastp = ~lastp; pulse(lastp, 1'b1, 1'b0, "R4"); nb++;
        end else empty("R5");
        i++;
      end
    end
    lastp = ~lastp; pulse(lastp, 1'b1, 1'b0, "R6");
    pulse(lastp, 1'b1, 1'b1, "R6");
    empty("R6");
    pulse(lastp, 1'b1, 1'b1, "R6");
    drive(1'b1, 1'b1, 1'b1, 1'b1, "R7");
    lastp = ~lastp; pulse(lastp, 1'b1, 1'b0, "R7");
    empty("R4"); empty("R4");
    pulse(lastp, 1'b0, 1'b0, "R4");
    empty("R4"); empty("R4");

    begin_phase(1'b0);
    pos_in = 1'b1; neg_in = 1'b1;
    repeat (65540) @(negedge clk);
    check("R9", {16'd0, viol_count}, 32'd65535);
    pos_in = 1'b0; neg_in = 1'b0; cnt_clr = 1'b1;
    @(negedge clk);
    check("R10", {16'd0, viol_count}, 32'd0);
    pos_in = 1'b1; neg_in = 1'b1;
    @(negedge clk);
    check("R10", {16'd0, viol_count}, 32'd1);
    check("R10", {31'd0, viol_pulse}, 32'd1);
    cnt_clr = 1'b0;
    @(negedge clk);
    check("R8", {16'd0, viol_count}, 32'd2);
    pos_in = 1'b0; neg_in = 1'b0;
    @(negedge clk);
    check("R8", {31'd0, viol_pulse}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule